// File: doc/BRIEF.md
# Switched-Select Carry/Borrow Arithmetic-Logic Unit

This block is a parameterised N-bit arithmetic/logic unit made from a row of identical bit slices. Each slice forwards the link between slices (a carry or a borrow) through a small select keyed only by its own operand bits. That select forces the link to 0, forces it to 1, or passes the incoming link straight through. The result bit of each slice comes from an 8-entry truth table supplied by the caller. The table is indexed by the slice's operand bits and the link that reaches it, so any function of those three bits can be produced.

A two-bit mode picks one of four behaviours. In addition the carry chain is used. In A minus B and in B minus A a separate borrow chain is used; it is non-inverting, so a borrow of 1 means "take one more away". In pass-through mode the incoming link reaches every slice unchanged, and the table alone sets the per-bit logic. Exactly one chain drives the link in any arithmetic mode. The block is purely combinational and has no clock. Its ports are plain control and data pins with no valid/ready flow control: each output follows the inputs once they settle.

Top module: `csw_alu`

## Requirements
- R1: With mode 2'b00 (add) and table 8'h96, {link_o, y_o} equals a_i + b_i + link_i.
- R2: With mode 2'b01 (A minus B) and table 8'h96, y_o equals (a_i - b_i - link_i) mod 2^N. link_o is 1 exactly when a_i < b_i + link_i.
- R3: With mode 2'b10 (B minus A) and table 8'h96, y_o equals (b_i - a_i - link_i) mod 2^N. link_o is 1 exactly when b_i < a_i + link_i.
- R4: With mode 2'b11 (pass-through), link_o equals link_i, and y_o[i] equals tbl_i[{a_i[i], b_i[i], link_i}]. Examples: table 8'hC0 gives AND, 8'hFC gives OR, 8'h96 gives a_i ^ b_i ^ link_i.
- R5: In every mode, y_o[i] is tbl_i indexed by {a_i[i], b_i[i], link into slice i}, with the operand A bit as the MSB. With table 8'hAA, y_o shows the link into each slice: (sum ^ a_i ^ b_i) for add, and (difference ^ a_i ^ b_i) for A minus B.
- R6: Each slice's outgoing link depends only on its operand bits. In add mode the slice kills on 00, propagates on 01 or 10, and generates on 11. In A minus B it propagates on equal bits, generates on 01 and kills on 10. In B minus A the roles of A and B are swapped.
- R7: At most one chain (carry or borrow) is enabled in a slice at any time. In pass-through mode neither is enabled.
- R8: The longest ripples resolve. In add mode, all ones + 0 with carry-in 1 gives 0 and carry-out 1. In A minus B, 0 - 0 with borrow-in 1 gives all ones and borrow-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| link_i | input | 1 | Carry-in or borrow-in, as the mode selects |
| mode_i | input | 2 | 00 add, 01 A minus B, 10 B minus A, 11 pass-through |
| tbl_i | input | 8 | Result truth table, indexed by {A bit, B bit, incoming link} |
| y_o | output | WIDTH | Result word |
| link_o | output | 1 | Final carry-out or borrow-out; equals link_i in pass-through |

## Verification
The hardest case to reach from the ports is a link that crosses every slice. Random operands almost never make every slice propagate, so the full-length carry and borrow ripples are driven on purpose: all-ones plus zero, and zero minus zero with a borrow-in. The internal link values cannot be seen directly. The bench exposes them by loading the table 8'hAA, which copies the link into each slice onto y_o. It then compares that word with the carry or borrow vector it works out from ordinary arithmetic.

// File: rtl/csw_pkg.sv
package csw_pkg;
  typedef enum logic [1:0] {
    MODE_ADD  = 2'b00,
    MODE_AMB  = 2'b01,
    MODE_BMA  = 2'b10,
    MODE_PASS = 2'b11
  } csw_mode_e;

  localparam int unsigned TBL_W = 8;
endpackage

// File: rtl/csw_link_sel.sv
module csw_link_sel
  import csw_pkg::*;
(
  input  logic      a,
  input  logic      b,
  input  logic      lin,
  input  csw_mode_e mode,
  output logic      lout
);
  logic carry_en, borrow_en, swap;
  logic carry_pick, borrow_pick;
  logic x, y;

  always_comb begin
    carry_en  = (mode == MODE_ADD);
    borrow_en = (mode == MODE_AMB) || (mode == MODE_BMA);
    swap      = (mode == MODE_BMA);
    x = swap ? b : a;
    y = swap ? a : b;

    case ({a, b})
      2'b00:   carry_pick = 1'b0;
      2'b11:   carry_pick = 1'b1;
      default: carry_pick = lin;
    endcase

    case ({x, y})
      2'b01:   borrow_pick = 1'b1;
      2'b10:   borrow_pick = 1'b0;
      default: borrow_pick = lin;
    endcase

    if (carry_en)       lout = carry_pick;
    else if (borrow_en) lout = borrow_pick;
    else                lout = lin;

    // R7: only one chain may drive the link
    a_r7_one_chain: assert ($onehot0({carry_en, borrow_en}));
    // R6: add is the majority of a, b and the incoming carry
    a_r6_add_gpk: assert (!carry_en || lout == ((a & b) | (lin & (a | b))));
    // R6: the borrow rule for x - y - lin
    a_r6_sub_gpk: assert (!borrow_en || lout == ((~x & y) | (lin & ~(x ^ y))));
    // R4: pass-through leaves the link untouched
    a_r4_pass_link: assert (mode != MODE_PASS || lout == lin);
  end
endmodule

// File: rtl/csw_bit_tbl.sv
module csw_bit_tbl
  import csw_pkg::*;
(
  input  logic [TBL_W-1:0] tbl,
  input  logic             a,
  input  logic             b,
  input  logic             c,
  output logic             y
);
  logic [2:0] idx;

  always_comb begin
    idx = {a, b, c};
    y   = tbl[idx];
    // R1: the standard table gives the three-input XOR
    a_r1_xor_sum: assert (tbl != 8'h96 || y == (a ^ b ^ c));
  end
endmodule

// File: rtl/csw_slice.sv
module csw_slice
  import csw_pkg::*;
(
  input  logic             a,
  input  logic             b,
  input  logic             lin,
  input  csw_mode_e        mode,
  input  logic [TBL_W-1:0] tbl,
  output logic             y,
  output logic             lout
);
  csw_link_sel u_link (
    .a    (a),
    .b    (b),
    .lin  (lin),
    .mode (mode),
    .lout (lout)
  );

  csw_bit_tbl u_res (
    .tbl (tbl),
    .a   (a),
    .b   (b),
    .c   (lin),
    .y   (y)
  );
endmodule

// File: rtl/csw_alu.sv
module csw_alu
  import csw_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             link_i,
  input  logic [1:0]       mode_i,
  input  logic [TBL_W-1:0] tbl_i,
  output logic [WIDTH-1:0] y_o,
  output logic             link_o
);
  localparam int unsigned NLINK = WIDTH + 1;

  csw_mode_e        mode;
  logic [NLINK-1:0] chain;

  assign mode     = csw_mode_e'(mode_i);
  assign chain[0] = link_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    csw_slice u_slice (
      .a    (a_i[i]),
      .b    (b_i[i]),
      .lin  (chain[i]),
      .mode (mode),
      .tbl  (tbl_i),
      .y    (y_o[i]),
      .lout (chain[i+1])
    );
  end

  assign link_o = chain[WIDTH];
endmodule

// File: tb/tb_csw_alu.sv
`timescale 1ns/1ps
module tb_csw_alu;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, y;
  logic         lin, lout;
  logic [1:0]   mode;
  logic [7:0]   tbl;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  csw_alu #(.WIDTH(W)) dut (
    .a_i(a), .b_i(b), .link_i(lin), .mode_i(mode), .tbl_i(tbl),
    .y_o(y), .link_o(lout)
  );

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input logic [1:0] mv, input logic [7:0] tv);
    @(negedge clk);
    a = av; b = bv; lin = cv; mode = mv; tbl = tv;
    #2;
  endtask

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h c=%b m=%b t=%h)",
               req, act, exp, a, b, lin, mode, tbl);
    end
  endtask

  function automatic logic [W:0] ref_arith(input logic [1:0] m, input logic [W-1:0] av,
                                           input logic [W-1:0] bv, input logic cv);
    logic [W:0] r;
    case (m)
      2'b00:   r = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
      2'b01:   r = {1'b0, av} - {1'b0, bv} - {{W{1'b0}}, cv};
      default: r = {1'b0, bv} - {1'b0, av} - {{W{1'b0}}, cv};
    endcase
    return r;
  endfunction

  task automatic t_reset_state;
    apply('0, '0, 1'b0, 2'b00, 8'h96);
    check("R1 zero", {lout, y}, '0);
  endtask

  task automatic t_add;
    logic [W-1:0] av, bv;
    apply(8'h5A, 8'h3C, 1'b1, 2'b00, 8'h96);
    check("R1 add", {lout, y}, ref_arith(2'b00, 8'h5A, 8'h3C, 1'b1));
    for (int k = 0; k < 40; k++) begin
      av = W'($urandom); bv = W'($urandom);
      apply(av, bv, 1'($urandom), 2'b00, 8'h96);
      check("R1 add rnd", {lout, y}, ref_arith(2'b00, av, bv, lin));
    end
  endtask

  task automatic t_amb;
    logic [W-1:0] av, bv;
    apply(8'h10, 8'h20, 1'b0, 2'b01, 8'h96);
    check("R2 a-b neg", {lout, y}, {1'b1, 8'hF0});
    for (int k = 0; k < 40; k++) begin
      av = W'($urandom); bv = W'($urandom);
      apply(av, bv, 1'($urandom), 2'b01, 8'h96);
      check("R2 a-b rnd", {lout, y}, ref_arith(2'b01, av, bv, lin));
    end
  endtask

  task automatic t_bma;
    logic [W-1:0] av, bv;
    apply(8'h20, 8'h10, 1'b0, 2'b10, 8'h96);
    check("R3 b-a neg", {lout, y}, {1'b1, 8'hF0});
    apply(8'h01, 8'h09, 1'b1, 2'b10, 8'h96);
    check("R3 b-a pos", {lout, y}, {1'b0, 8'h07});
    for (int k = 0; k < 40; k++) begin
      av = W'($urandom); bv = W'($urandom);
      apply(av, bv, 1'($urandom), 2'b10, 8'h96);
      check("R3 b-a rnd", {lout, y}, ref_arith(2'b10, av, bv, lin));
    end
  endtask

  task automatic t_pass;
    apply(8'hCA, 8'hA6, 1'b1, 2'b11, 8'hC0);
    check("R4 and", {lout, y}, {1'b1, 8'hCA & 8'hA6});
    apply(8'hCA, 8'hA6, 1'b0, 2'b11, 8'hFC);
    check("R4 or", {lout, y}, {1'b0, 8'hCA | 8'hA6});
    apply(ONES, ONES, 1'b1, 2'b11, 8'h96);
    check("R4 xor no ripple", {lout, y}, {1'b1, ONES});
    apply(8'h0F, 8'h33, 1'b1, 2'b11, 8'hAA);
    check("R4 cin copy", {lout, y}, {1'b1, ONES});
  endtask

  task automatic t_table_links;
    logic [W-1:0] av, bv;
    logic [W:0]   r;
    for (int k = 0; k < 20; k++) begin
      av = W'($urandom); bv = W'($urandom);
      apply(av, bv, 1'($urandom), 2'b00, 8'hAA);
      r = ref_arith(2'b00, av, bv, lin);
      check("R5 carry vector", {lout, y}, {r[W], r[W-1:0] ^ av ^ bv});
      apply(av, bv, 1'($urandom), 2'b01, 8'hAA);
      r = ref_arith(2'b01, av, bv, lin);
      check("R5 borrow vector", {lout, y}, {r[W], r[W-1:0] ^ av ^ bv});
    end
  endtask

  task automatic t_gpk;
    // R6: single-slice rules seen at link_o with W-bit operands of one set bit pattern
    apply(ONES, ONES, 1'b0, 2'b00, 8'h96);
    check("R6 add generate", {1'b0, lout}, {{W{1'b0}}, 1'b1});
    apply('0, '0, 1'b1, 2'b00, 8'h96);
    check("R6 add kill", {lout, y}, {1'b0, 8'h01});
    apply('0, ONES, 1'b0, 2'b01, 8'h96);
    check("R6 a-b generate", {lout, y}, {1'b1, 8'h01});
    apply(ONES, '0, 1'b1, 2'b01, 8'h96);
    check("R6 a-b kill", {lout, y}, {1'b0, 8'hFE});
    apply(ONES, '0, 1'b0, 2'b10, 8'h96);
    check("R6 b-a swapped", {lout, y}, {1'b1, 8'h01});
  endtask

  task automatic t_chain_sel;
    // R7: pass mode ignores operands for the link; arithmetic modes use their own chain
    apply(ONES, '0, 1'b0, 2'b11, 8'h00);
    check("R7 pass no chain", {lout, y}, '0);
    apply(ONES, '0, 1'b1, 2'b00, 8'hAA);
    check("R7 carry chain only", {lout, y}, {1'b1, ONES});
  endtask

  task automatic t_ripple;
    apply(ONES, '0, 1'b1, 2'b00, 8'h96);
    check("R8 full carry ripple", {lout, y}, {1'b1, {W{1'b0}}});
    apply('0, '0, 1'b1, 2'b01, 8'h96);
    check("R8 full borrow ripple", {lout, y}, {1'b1, ONES});
    apply('0, '0, 1'b1, 2'b10, 8'h96);
    check("R8 full b-a ripple", {lout, y}, {1'b1, ONES});
    apply(ONES, ONES, 1'b1, 2'b01, 8'h96);
    check("R8 equal ops borrow", {lout, y}, {1'b1, ONES});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; lin = 1'b0; mode = 2'b00; tbl = 8'h96;
    t_reset_state();
    t_add();
    t_amb();
    t_bma();
    t_pass();
    t_table_links();
    t_gpk();
    t_chain_sel();
    t_ripple();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule